// File: doc/BRIEF.md
# Sextant Majority Trigger Merger

This block turns thirty chamber hit multiplicities into a six-bit trigger code. Three receiver units each deliver ten 4-bit multiplicities. Every multiplicity is compared with one shared programmable threshold, which gives one hit bit per chamber. The thirty chambers form six sextants of five planes each. A sextant fires when at least a programmable number of its five plane bits are set.

The six sextant bits form the trigger code. Their OR is a single global trigger. Both are registered and appear a fixed two clocks after the multiplicities are presented. Each sextant also has a saturating scaler. It counts the clocks in which that sextant fired, so that trigger rates can be monitored, and a synchronous command clears it. The serial links that feed the block and the downstream trigger interface lie outside it.

Top module: `sextant_trigger_merger`

## Requirements
- R1: Chamber c of receiver r (r = 0..2, c = 0..9) has global index 10*r + c and sits at bits [4c+3:4c] of that receiver's bus. Sextant s (bit s of the trigger code) owns chambers 5s to 5s+4.
- R2: A chamber's hit bit is set only when its multiplicity is strictly greater than the threshold. Equality does not count.
- R3: For a need value x from 1 to 5, a sextant fires when at least x of its five hit bits are set. Any x above 5 behaves exactly as 5.
- R4: A need value of 0 disables voting, and no sextant fires.
- R5: The global trigger output equals the OR of the six trigger code bits in every cycle.
- R6: A multiplicity pattern and threshold presented before clock edge n produce the trigger code after edge n+1. The need value is sampled one edge later than the multiplicities.
- R7: Each sextant scaler adds one on every clock edge at which its trigger code bit is high. It holds at its all-ones maximum instead of wrapping.
- R8: While the clear input is high at a clock edge, all scalers become zero. The clear takes priority over counting.
- R9: An active-low asynchronous reset forces the hit bits, the trigger code, the global trigger and all scalers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx0_mult | input | 40 | Multiplicities of chambers 0-9, 4 bits each |
| rx1_mult | input | 40 | Multiplicities of chambers 10-19, 4 bits each |
| rx2_mult | input | 40 | Multiplicities of chambers 20-29, 4 bits each |
| hit_thr | input | 4 | Chamber threshold (hit when multiplicity > threshold) |
| maj_need | input | 3 | Planes required per sextant (0 disables, above 5 acts as 5) |
| scaler_clr | input | 1 | Synchronous clear of all scalers |
| trig_code | output | 6 | Registered sextant trigger code, bit s is sextant s |
| trig_any | output | 1 | Registered OR of the trigger code |
| scaler_flat | output | 6*SCALER_W | Sextant scalers, sextant s at bits [s*SCALER_W +: SCALER_W] |

## Verification
The assertions assume that the multiplicities, the threshold, the need value and the clear are known values at every clock edge after reset. They also assume that reset is released only while those inputs are defined, because the properties compare hit bits and scalers with the input values that one `$past` step earlier held. The bench changes every input on the falling clock edge. It holds each pattern for at least three rising edges before it samples, so every check lands after the two-stage pipeline has settled. The latency test is the one exception: it samples on purpose after one edge and after two.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int SECTORS   = 6;
  localparam int PLANES    = 5;
  localparam int RX_UNITS  = 3;
  localparam int CH_PER_RX = 10;
  localparam int MULT_W    = 4;
  localparam int NEED_W    = 3;
  localparam int CHAMBERS  = SECTORS * PLANES;
  localparam int RX_BUS_W  = CH_PER_RX * MULT_W;

  // chamber hit rule: strictly above threshold
  function automatic logic above_thr(input logic [MULT_W-1:0] m,
                                     input logic [MULT_W-1:0] t);
    return m > t;
  endfunction

  // need value clamp: values beyond the plane count act as all planes
  function automatic logic [NEED_W-1:0] clamp_need(input logic [NEED_W-1:0] x);
    return (x > NEED_W'(PLANES)) ? NEED_W'(PLANES) : x;
  endfunction

  function automatic logic [NEED_W-1:0] plane_count(input logic [PLANES-1:0] p);
    logic [NEED_W-1:0] n;
    n = '0;
    for (int i = 0; i < PLANES; i++) n = n + NEED_W'(p[i]);
    return n;
  endfunction

  function automatic logic majority(input logic [PLANES-1:0] p,
                                    input logic [NEED_W-1:0] x);
    logic [NEED_W-1:0] need;
    need = clamp_need(x);
    return (need != '0) && (plane_count(p) >= need);
  endfunction
endpackage

// File: rtl/smt_chamber_cmp.sv
module smt_chamber_cmp
  import smt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CHAMBERS*MULT_W-1:0] mult_all,
  input  logic [MULT_W-1:0]          hit_thr,
  output logic [CHAMBERS-1:0]        hit_q
);
  for (genvar c = 0; c < CHAMBERS; c++) begin : g_ch
    logic hit_d;
    assign hit_d = above_thr(mult_all[c*MULT_W +: MULT_W], hit_thr);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q[c] <= 1'b0;
      else        hit_q[c] <= hit_d;
    end
  end
endmodule

// File: rtl/smt_sextant_vote.sv
module smt_sextant_vote
  import smt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHAMBERS-1:0] hit_q,
  input  logic [NEED_W-1:0]   maj_need,
  output logic [SECTORS-1:0]  vote_now,
  output logic [SECTORS-1:0]  code_q,
  output logic                any_q
);
  for (genvar s = 0; s < SECTORS; s++) begin : g_sx
    assign vote_now[s] = majority(hit_q[s*PLANES +: PLANES], maj_need);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[s] <= 1'b0;
      else        code_q[s] <= vote_now[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= |vote_now;
  end
endmodule

// File: rtl/smt_scaler_bank.sv
module smt_scaler_bank
  import smt_pkg::*;
#(
  parameter int SCALER_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SECTORS-1:0]           fired,
  input  logic                         clr,
  output logic [SECTORS*SCALER_W-1:0]  cnt_flat
);
  localparam logic [SCALER_W-1:0] CNT_MAX = '1;

  for (genvar s = 0; s < SECTORS; s++) begin : g_cnt
    logic [SCALER_W-1:0] cnt_q;
    logic                at_max;
    assign at_max = (cnt_q == CNT_MAX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr)                cnt_q <= '0;
      else if (fired[s] && !at_max) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_flat[s*SCALER_W +: SCALER_W] = cnt_q;
  end
endmodule

// File: rtl/sextant_trigger_merger.sv
module sextant_trigger_merger
  import smt_pkg::*;
#(
  parameter int SCALER_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RX_BUS_W-1:0]          rx0_mult,
  input  logic [RX_BUS_W-1:0]          rx1_mult,
  input  logic [RX_BUS_W-1:0]          rx2_mult,
  input  logic [MULT_W-1:0]            hit_thr,
  input  logic [NEED_W-1:0]            maj_need,
  input  logic                         scaler_clr,
  output logic [SECTORS-1:0]           trig_code,
  output logic                         trig_any,
  output logic [SECTORS*SCALER_W-1:0]  scaler_flat
);
  logic [CHAMBERS*MULT_W-1:0] mult_all;
  logic [CHAMBERS-1:0]        chamber_hit_q;
  logic [SECTORS-1:0]         vote_now;

  // R1: receiver 0 holds chambers 0-9, receiver 2 holds chambers 20-29
  assign mult_all = {rx2_mult, rx1_mult, rx0_mult};

  smt_chamber_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mult_all (mult_all),
    .hit_thr  (hit_thr),
    .hit_q    (chamber_hit_q)
  );

  smt_sextant_vote u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_q    (chamber_hit_q),
    .maj_need (maj_need),
    .vote_now (vote_now),
    .code_q   (trig_code),
    .any_q    (trig_any)
  );

  smt_scaler_bank #(.SCALER_W(SCALER_W)) u_scal (
    .clk      (clk),
    .rst_n    (rst_n),
    .fired    (trig_code),
    .clr      (scaler_clr),
    .cnt_flat (scaler_flat)
  );
endmodule

// File: rtl/smt_checker.sv
module smt_checker
  import smt_pkg::*;
#(
  parameter int SCALER_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [CHAMBERS*MULT_W-1:0]   mult_all,
  input logic [MULT_W-1:0]            hit_thr,
  input logic [NEED_W-1:0]            maj_need,
  input logic                         scaler_clr,
  input logic [CHAMBERS-1:0]          chamber_hit_q,
  input logic [SECTORS-1:0]           trig_code,
  input logic                         trig_any,
  input logic [SECTORS*SCALER_W-1:0]  scaler_flat
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r5_any_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (trig_any == (|trig_code)));

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(maj_need) == '0) |-> (trig_code == '0));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(scaler_clr)) |-> (scaler_flat == '0));

  for (genvar c = 0; c < CHAMBERS; c++) begin : g_hit
    a_r2_hit_rule: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (chamber_hit_q[c] ==
                 ($past(mult_all[c*MULT_W +: MULT_W]) > $past(hit_thr))));
  end

  for (genvar s = 0; s < SECTORS; s++) begin : g_sx
    a_r3_need_five: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(maj_need) >= NEED_W'(PLANES) && trig_code[s])
        |-> ($past(chamber_hit_q[s*PLANES +: PLANES]) == '1));

    a_r7_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(scaler_clr))
        |-> (scaler_flat[s*SCALER_W +: SCALER_W] >=
             $past(scaler_flat[s*SCALER_W +: SCALER_W])));

    a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ({1'b0, scaler_flat[s*SCALER_W +: SCALER_W]} <=
                 {1'b0, $past(scaler_flat[s*SCALER_W +: SCALER_W])} + 1'b1));
  end
endmodule

bind sextant_trigger_merger smt_checker #(.SCALER_W(SCALER_W)) u_smt_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mult_all      (mult_all),
  .hit_thr       (hit_thr),
  .maj_need      (maj_need),
  .scaler_clr    (scaler_clr),
  .chamber_hit_q (chamber_hit_q),
  .trig_code     (trig_code),
  .trig_any      (trig_any),
  .scaler_flat   (scaler_flat)
);

// File: tb/test_sextant_trigger_merger.sv
`timescale 1ns/1ps
module test_sextant_trigger_merger;
  localparam int SW = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [39:0]  rx0_mult = '0, rx1_mult = '0, rx2_mult = '0;
  logic [3:0]   hit_thr = '0;
  logic [2:0]   maj_need = '0;
  logic         scaler_clr = 1'b0;
  logic [5:0]   trig_code;
  logic         trig_any;
  logic [6*SW-1:0] scaler_flat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  sextant_trigger_merger #(.SCALER_W(SW)) i_sextant_trigger_merger (
    .clk(clk), .rst_n(rst_n), .rx0_mult(rx0_mult), .rx1_mult(rx1_mult),
    .rx2_mult(rx2_mult), .hit_thr(hit_thr), .maj_need(maj_need),
    .scaler_clr(scaler_clr), .trig_code(trig_code), .trig_any(trig_any),
    .scaler_flat(scaler_flat));

  typedef struct packed {
    logic [29:0] mask;  // chambers that receive the high value
    logic [3:0]  hi;
    logic [3:0]  lo;
    logic [3:0]  thr;
    logic [2:0]  need;
    logic [5:0]  expc;  // expected trigger code
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{30'h3FFFFFFF, 4'd9,  4'd0,  4'd8,  3'd5, 6'h3F},  // R3 all planes
    '{30'h3FFFFFFF, 4'd8,  4'd0,  4'd8,  3'd1, 6'h00},  // R2 equal is no hit
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd3, 6'h25},  // R3 x=3
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd2, 6'h27},  // R3 x=2
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd0, 6'h00},  // R4 disabled
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd7, 6'h04},  // R3 clamp 7
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd1, 6'h37},  // R3 x=1
    '{30'h00000000, 4'd0,  4'd15, 4'd14, 3'd5, 6'h3F},  // R2 low value path
    '{30'h00000000, 4'd0,  4'd15, 4'd15, 3'd1, 6'h00},  // R2 max threshold
    '{30'h00000600, 4'd5,  4'd0,  4'd0,  3'd1, 6'h06},  // R1 chambers 9,10
    '{30'h00180000, 4'd5,  4'd0,  4'd0,  3'd1, 6'h18},  // R1 chambers 19,20
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd6, 6'h04},  // R3 clamp 6
    '{30'h1F007C67, 4'd15, 4'd3,  4'd3,  3'd4, 6'h24}   // R3 x=4
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    logic [119:0] bus;
    for (int c = 0; c < 30; c++) bus[c*4 +: 4] = v.mask[c] ? v.hi : v.lo;
    rx0_mult = bus[39:0];
    rx1_mult = bus[79:40];
    rx2_mult = bus[119:80];
    hit_thr  = v.thr;
    maj_need = v.need;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9 reset state
    #10;
    check("R9 code in reset", 64'(trig_code), 0);
    check("R9 scalers in reset", 64'(scaler_flat), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      repeat (3) @(negedge clk);
      check($sformatf("R3 code vec %0d", i), 64'(trig_code), 64'(VECS[i].expc));
      check($sformatf("R5 any vec %0d", i), 64'(trig_any), 64'(|VECS[i].expc));
    end

    // R6 latency: zero pattern, then all-fire pattern
    drive('{30'h0, 4'd0, 4'd0, 4'd8, 3'd5, 6'h0});
    repeat (3) @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    check("R6 one edge later", 64'(trig_code), 0);
    @(negedge clk);
    check("R6 two edges later", 64'(trig_code), 64'h3F);

    // R7/R8 scalers with code 0x25 held
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    scaler_clr = 1'b1;
    @(negedge clk);
    scaler_clr = 1'b0;
    check("R8 clear beats counting", 64'(scaler_flat), 0);
    repeat (10) @(negedge clk);
    for (int s = 0; s < 6; s++)
      check($sformatf("R7 count lane %0d", s), 64'(scaler_flat[s*SW +: SW]),
            (s == 0 || s == 2 || s == 5) ? 64'd10 : 64'd0);
    repeat (300) @(negedge clk);
    for (int s = 0; s < 6; s++)
      check($sformatf("R7 saturate lane %0d", s), 64'(scaler_flat[s*SW +: SW]),
            (s == 0 || s == 2 || s == 5) ? 64'd255 : 64'd0);
    scaler_clr = 1'b1;
    @(negedge clk);
    scaler_clr = 1'b0;
    check("R8 clear after saturation", 64'(scaler_flat), 0);

    // R9 asynchronous reset mid-run
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async code", 64'(trig_code), 0);
    check("R9 async any", 64'(trig_any), 0);
    check("R9 async scalers", 64'(scaler_flat), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 resume after reset", 64'(trig_code), 64'h25);

    finish_run();
  end
endmodule